// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is one data counter of a performance-monitoring unit in a core that runs two hardware threads. Each clock an upstream selection stage presents a small per-cycle event count. The counter decides whether that count, or a filtered 0/1 version of it, is added to a 40-bit accumulator. The decision depends on a 64-bit control word that software writes.

The filter has three parts. A threshold comparator can replace the raw count by a single bit, and its sense can be inverted. An edge detector can reduce the comparator output to one increment per rising transition. A gate passes counting only when the two thread-active flags match one of four activity modes. Counting can also be held back until a neighbouring counter reports an overflow, which lets two counters form a chain.

When the accumulator wraps, the counter sets a sticky flag in the control word. In the following cycle it raises a one-cycle request on either or both per-thread interrupt lines. A debug mode treats every non-zero increment as an overflow. Software can load any starting value through a separate count write port.

Top module: `perf_evt_counter`

## Requirements
- R1: After a synchronous active-low reset, the count, the whole control word and both interrupt lines are zero.
- R2: Only control bits 12 to 27, 30 and 31 are storable, so the readback mask is 0x00000000CFFFF000. Every other bit reads back as zero whatever was written.
- R3: An increment happens only when enable (bit 12) is set and the thread gate (bits 17:16) passes. The number of active threads is taken from the two flags. The gate passes for that number as follows: mode 0 when it is zero, mode 1 when it is exactly one, mode 2 when it is two, and mode 3 when it is one or more.
- R4: With compare (bit 18) clear, the increment is the full per-cycle event count.
- R5: With compare set, the increment is 1 when the comparator is true and 0 otherwise. The threshold is bits 23:20. The comparator tests count > threshold when complement (bit 19) is clear, and count <= threshold when it is set.
- R6: With edge (bit 24) and compare both set, the increment is 1 only when the comparator is true in this cycle and was false in the previous cycle. The comparator is evaluated every cycle.
- R7: The count is 40 bits wide and wraps from all-ones to zero. A wrap sets the overflow flag (bit 31). The flag stays set until a control write clears it.
- R8: An overflow event drives interrupt line 0 high for exactly one cycle, one cycle later, when bit 26 is set. It does the same for interrupt line 1 when bit 27 is set.
- R9: With force overflow (bit 25) set, every non-zero increment is an overflow event. It sets bit 31 and raises the enabled interrupt lines.
- R10: With cascade (bit 30) set, no increment happens until an alternate-overflow pulse has been seen. Counting begins in the cycle after the pulse. Any control write clears this armed state.
- R11: A count load takes the written value and replaces that cycle's increment. A load never produces an overflow event.
- R12: A control write takes effect in the cycle after it, and the cycle of the write still runs under the old word. An overflow in the same cycle as a write that clears bit 31 leaves bit 31 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 64 | Control word write value |
| cnt_wr_en | input | 1 | Count load strobe |
| cnt_wr_data | input | 40 | Count load value |
| evt_cnt | input | 4 | Per-cycle event count from the selection stage |
| thr_active | input | 2 | Active flags of thread 1 and thread 0 |
| alt_ovf | input | 1 | Overflow pulse of the alternate counter |
| ctl_rd_data | output | 64 | Current control word |
| count_q | output | 40 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag (control bit 31) |
| irq_t0 | output | 1 | Interrupt request to thread 0 |
| irq_t1 | output | 1 | Interrupt request to thread 1 |

## Verification
The bench sweeps every thread mode against every activity pattern and every event count. It also sweeps every threshold against every count in both comparator senses. A swapped mode decode or an off-by-one in the comparison would show up as a count that drifts from the arithmetic expectation. Edge sequences catch a detector that counts level instead of transitions or that only samples while enabled. Loads near the wrap point check several things: that the flag stays sticky, that the interrupt pulse comes one cycle late and only for enabled threads, that a write cannot erase an overflow happening in the same cycle, and that a load does not report a false wrap. The cascade sequence checks that counting waits for the alternate pulse and stops again after a rewrite.

// File: rtl/pec_pkg.sv
// Package: shared constants and types for the filtered performance event counter.
// Assumes a 64-bit control word; bit positions are fixed because software encodes them.
package pec_pkg;
    localparam int CTL_W = 64;
    localparam logic [CTL_W-1:0] CTL_KEEP_MASK = 64'h0000_0000_CFFF_F000;

    localparam int B_ENABLE  = 12;
    localparam int B_MODE_LO = 16;
    localparam int B_CMP     = 18;
    localparam int B_COMPL   = 19;
    localparam int B_THR_LO  = 20;
    localparam int B_EDGE    = 24;
    localparam int B_FORCE   = 25;
    localparam int B_IRQ0    = 26;
    localparam int B_IRQ1    = 27;
    localparam int B_CASCADE = 30;
    localparam int B_OVF     = 31;
    localparam int THR_W     = 4;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_ONE  = 2'b01,
        ACT_BOTH = 2'b10,
        ACT_ANY  = 2'b11
    } act_mode_e;

    typedef struct packed {
        logic             enable;
        act_mode_e        mode;
        logic             cmp_en;
        logic             compl_en;
        logic [THR_W-1:0] thr;
        logic             edge_en;
        logic             cascade;
    } filt_cfg_t;

    // Extract the fields the filter stage needs from a control word.
    function automatic filt_cfg_t get_filt_cfg(input logic [CTL_W-1:0] w);
        filt_cfg_t c;
        c.enable   = w[B_ENABLE];
        c.mode     = act_mode_e'(w[B_MODE_LO +: 2]);
        c.cmp_en   = w[B_CMP];
        c.compl_en = w[B_COMPL];
        c.thr      = w[B_THR_LO +: THR_W];
        c.edge_en  = w[B_EDGE];
        c.cascade  = w[B_CASCADE];
        return c;
    endfunction
endpackage

// File: rtl/pec_ctl_reg.sv
// Module: control word register.
// Stores only the writable bits. It ORs in the overflow flag whenever the
// accumulator reports an overflow, even in the cycle of a software write.
// Assumes ovf_set is a single-cycle event from the accumulator.
module pec_ctl_reg
    import pec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             ovf_set,
    output logic [CTL_W-1:0] ctl_q
);
    logic [CTL_W-1:0] ctl_d;

    // Next value: masked write or hold, then overflow flag merge.
    always_comb begin
        ctl_d = wr_en ? (wr_data & CTL_KEEP_MASK) : ctl_q;
        if (ovf_set) ctl_d[B_OVF] = 1'b1;
    end

    // Control word state.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_q[B_OVF]) && !$past(wr_en)) |-> ctl_q[B_OVF]);
    // R12
    ovf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> ctl_q[B_OVF]);
endmodule

// File: rtl/pec_filter.sv
// Module: event filter.
// Applies threshold compare, complement, edge detection, thread gating and
// cascade arming, and produces the increment for the current cycle.
// Assumes the configuration comes from the registered control word.
module pec_filter
    import pec_pkg::*;
#(
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  filt_cfg_t        cfg,
    input  logic             ctl_wr_en,
    input  logic [EVT_W-1:0] evt_cnt,
    input  logic [1:0]       thr_active,
    input  logic             alt_ovf,
    output logic [EVT_W-1:0] inc_amt
);
    localparam int CW = (EVT_W > THR_W) ? EVT_W : THR_W;

    logic [CW-1:0] evt_x, thr_x;
    logic          cmp_raw;
    logic          prev_cmp_q;
    logic          armed_q;
    logic          gate_ok;
    logic          run;
    logic [1:0]    n_active;

    // Comparator with selectable sense.
    always_comb begin
        evt_x   = CW'(evt_cnt);
        thr_x   = CW'(cfg.thr);
        cmp_raw = cfg.compl_en ? (evt_x <= thr_x) : (evt_x > thr_x);
    end

    // Thread activity gate.
    always_comb begin
        n_active = {1'b0, thr_active[0]} + {1'b0, thr_active[1]};
        unique case (cfg.mode)
            ACT_NONE: gate_ok = (n_active == 2'd0);
            ACT_ONE:  gate_ok = (n_active == 2'd1);
            ACT_BOTH: gate_ok = (n_active == 2'd2);
            default:  gate_ok = (n_active != 2'd0);
        endcase
    end

    // Previous comparator output for edge detection, sampled every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_cmp_q <= 1'b0;
        else        prev_cmp_q <= cmp_raw;
    end

    // Cascade arming: set by alternate overflow, cleared by any control write.
    always_ff @(posedge clk) begin
        if (!rst_n)                         armed_q <= 1'b0;
        else if (ctl_wr_en)                 armed_q <= 1'b0;
        else if (cfg.cascade && alt_ovf)    armed_q <= 1'b1;
    end

    // Increment selection.
    always_comb begin
        run = cfg.enable && gate_ok && (!cfg.cascade || armed_q);
        if (!run)
            inc_amt = '0;
        else if (!cfg.cmp_en)
            inc_amt = evt_cnt;
        else if (cfg.edge_en)
            inc_amt = EVT_W'(cmp_raw && !prev_cmp_q);
        else
            inc_amt = EVT_W'(cmp_raw);
    end

    // R5
    cmp_unit_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.cmp_en |-> (inc_amt <= EVT_W'(1)));
    // R6
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.cmp_en && cfg.edge_en && inc_amt != '0 && !ctl_wr_en) |=> (inc_amt == '0));
    // R3
    gate_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == ACT_NONE && thr_active != 2'b00) |-> (inc_amt == '0));
endmodule

// File: rtl/pec_accum.sv
// Module: wrapping accumulator.
// Adds the increment, detects the wrap past all-ones, handles software loads
// and issues registered per-thread interrupt pulses.
// Assumes a load replaces the increment of the same cycle.
module pec_accum #(
    parameter int CNT_W = 40,
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] inc_amt,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_data,
    input  logic             force_ovf,
    input  logic [1:0]       irq_en,
    output logic [CNT_W-1:0] count_q,
    output logic             ovf_evt,
    output logic [1:0]       irq_q
);
    logic [CNT_W:0] sum;

    // Sum with carry-out, and the overflow event.
    always_comb begin
        sum     = {1'b0, count_q} + (CNT_W+1)'(inc_amt);
        ovf_evt = !ld_en && (sum[CNT_W] || (force_ovf && inc_amt != '0));
    end

    // Count state: load has priority over the increment.
    always_ff @(posedge clk) begin
        if (!rst_n)     count_q <= '0;
        else if (ld_en) count_q <= ld_data;
        else            count_q <= sum[CNT_W-1:0];
    end

    // Interrupt pulses, one cycle after the overflow event.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_en & {2{ovf_evt}};
    end

    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && inc_amt == '0) |=> $stable(count_q));
    // R8
    irq_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q != 2'b00) |-> $past(ovf_evt));
endmodule

// File: rtl/perf_evt_counter.sv
// Module: top of the filtered performance event counter.
// Connects the control register, the filter and the accumulator.
// Assumes the event count is already selected and privilege-filtered upstream.
module perf_evt_counter
    import pec_pkg::*;
#(
    parameter int CNT_W = 40,
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_en,
    input  logic [63:0]      ctl_wr_data,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic [EVT_W-1:0] evt_cnt,
    input  logic [1:0]       thr_active,
    input  logic             alt_ovf,
    output logic [63:0]      ctl_rd_data,
    output logic [CNT_W-1:0] count_q,
    output logic             ovf_flag,
    output logic             irq_t0,
    output logic             irq_t1
);
    logic [CTL_W-1:0] ctl_q;
    filt_cfg_t        cfg;
    logic [EVT_W-1:0] inc_amt;
    logic             ovf_evt;
    logic [1:0]       irq_q;

    pec_ctl_reg i_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .ovf_set (ovf_evt),
        .ctl_q   (ctl_q)
    );

    // Decode the filter fields from the stored word.
    always_comb cfg = get_filt_cfg(ctl_q);

    pec_filter #(.EVT_W(EVT_W)) i_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .ctl_wr_en  (ctl_wr_en),
        .evt_cnt    (evt_cnt),
        .thr_active (thr_active),
        .alt_ovf    (alt_ovf),
        .inc_amt    (inc_amt)
    );

    pec_accum #(.CNT_W(CNT_W), .EVT_W(EVT_W)) i_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_amt   (inc_amt),
        .ld_en     (cnt_wr_en),
        .ld_data   (cnt_wr_data),
        .force_ovf (ctl_q[B_FORCE]),
        .irq_en    ({ctl_q[B_IRQ1], ctl_q[B_IRQ0]}),
        .count_q   (count_q),
        .ovf_evt   (ovf_evt),
        .irq_q     (irq_q)
    );

    // Output mapping.
    always_comb begin
        ctl_rd_data = ctl_q;
        ovf_flag    = ctl_q[B_OVF];
        irq_t0      = irq_q[0];
        irq_t1      = irq_q[1];
    end

    // R8
    irq0_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_t0 |-> ovf_flag);
    // R7
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_wr_en) && count_q < $past(count_q)) |-> ovf_flag);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_wr_en) |-> ((ctl_rd_data & ~CTL_KEEP_MASK) == '0));
endmodule

// File: tb/test_perf_evt_counter.sv
`timescale 1ns/1ps
module test_perf_evt_counter;
    localparam logic [63:0] KEEP = 64'h0000_0000_CFFF_F000;
    localparam longint unsigned CMAX = 64'h0000_00FF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [63:0] ctl_wr_data = '0;
    logic        cnt_wr_en = 1'b0;
    logic [39:0] cnt_wr_data = '0;
    logic [3:0]  evt_cnt = '0;
    logic [1:0]  thr_active = '0;
    logic        alt_ovf = 1'b0;
    logic [63:0] ctl_rd_data;
    logic [39:0] count_q;
    logic        ovf_flag, irq_t0, irq_t1;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [63:0]     m_ctl = '0;
    longint unsigned m_cnt = 0;
    bit m_prev = 0, m_arm = 0, m_irq0 = 0, m_irq1 = 0;

    always #2 clk = ~clk;

    perf_evt_counter i_perf_evt_counter (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .evt_cnt(evt_cnt),
        .thr_active(thr_active), .alt_ovf(alt_ovf), .ctl_rd_data(ctl_rd_data),
        .count_q(count_q), .ovf_flag(ovf_flag), .irq_t0(irq_t0), .irq_t1(irq_t1)
    );

    task automatic check_all(input string tag);
        checks++;
        if (count_q !== m_cnt[39:0] || ctl_rd_data !== m_ctl || ovf_flag !== m_ctl[31]
            || irq_t0 !== m_irq0 || irq_t1 !== m_irq1) begin
            fails++;
            $display("FAIL %s: actual cnt=%h ctl=%h irq=%b%b expected cnt=%h ctl=%h irq=%b%b",
                     tag, count_q, ctl_rd_data, irq_t1, irq_t0, m_cnt[39:0], m_ctl, m_irq1, m_irq0);
        end
    endtask

    // One clock: drive at the falling edge, model the rising edge, check at the next falling edge.
    task automatic cyc(input string tag, input bit wc, input logic [63:0] cd, input bit wl,
                       input logic [39:0] ld, input int ev, input logic [1:0] act, input bit alt);
        logic [63:0] c;
        bit cmpr, g, run, ov;
        int na, inc;
        longint unsigned sum;
        ctl_wr_en = wc; ctl_wr_data = cd; cnt_wr_en = wl; cnt_wr_data = ld;
        evt_cnt = 4'(ev); thr_active = act; alt_ovf = alt;
        @(posedge clk);
        c = m_ctl;
        cmpr = c[19] ? (ev <= int'(c[23:20])) : (ev > int'(c[23:20]));
        na = int'(act[0]) + int'(act[1]);
        case (c[17:16])
            2'd0: g = (na == 0);
            2'd1: g = (na == 1);
            2'd2: g = (na == 2);
            default: g = (na != 0);
        endcase
        run = c[12] && g && (!c[30] || m_arm);
        inc = !run ? 0 : (!c[18] ? ev : (c[24] ? int'(cmpr && !m_prev) : int'(cmpr)));
        m_prev = cmpr;
        if (wc) m_arm = 0; else if (c[30] && alt) m_arm = 1;
        if (wl) begin m_cnt = {24'd0, ld}; ov = 0; end
        else begin
            sum = m_cnt + longint'(inc);
            ov = (sum > CMAX) || (c[25] && inc != 0);
            m_cnt = sum & CMAX;
        end
        m_ctl = wc ? (cd & KEEP) : c;
        if (ov) m_ctl[31] = 1'b1;
        m_irq0 = ov && c[26];
        m_irq1 = ov && c[27];
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic wctl(input string tag, input logic [63:0] d);
        cyc(tag, 1, d, 0, '0, 0, 2'b00, 0);
    endtask

    task automatic wcnt(input string tag, input logic [39:0] d);
        cyc(tag, 0, '0, 1, d, 0, 2'b00, 0);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset state");

        // R2: all-ones write reads back masked
        wctl("R2 reserved mask", 64'hFFFF_FFFF_FFFF_FFFF);
        wctl("R2 clear", 64'h0);

        // R3 / R4: every mode against every activity pattern and count
        for (int md = 0; md < 4; md++) begin
            wctl("R3 mode write", 64'h1000 | (64'(md) << 16));
            for (int a = 0; a < 4; a++)
                for (int e = 0; e < 16; e++)
                    cyc("R3 R4 gate sweep", 0, '0, 0, '0, e, 2'(a), 0);
        end
        wctl("R3 disable", 64'h3_0000);
        for (int e = 0; e < 16; e++) cyc("R3 disabled", 0, '0, 0, '0, e, 2'b11, 0);

        // R5: threshold sweep in both senses
        for (int cp = 0; cp < 2; cp++)
            for (int t = 0; t < 16; t++) begin
                wctl("R5 cmp write", 64'h4_1000 | 64'h3_0000 | (64'(cp) << 19) | (64'(t) << 20));
                for (int e = 0; e < 16; e++) cyc("R5 threshold sweep", 0, '0, 0, '0, e, 2'b01, 0);
            end

        // R6: edge detection over mixed sequences, both senses
        for (int cp = 0; cp < 2; cp++) begin
            wctl("R6 edge write", 64'h0100_0000 | 64'h4_1000 | 64'h3_0000 | (64'(cp) << 19) | (64'd5 << 20));
            for (int i = 0; i < 60; i++) cyc("R6 edge seq", 0, '0, 0, '0, (i * 7 + i / 3) % 11, 2'b10, 0);
        end

        // R7 / R8: wrap with both interrupt lines, then only line 1
        wctl("R8 irq both", 64'h0C00_0000 | 64'h3_1000);
        wcnt("R11 load near wrap", 40'hFF_FFFF_FFFB);
        for (int i = 0; i < 4; i++) cyc("R7 R8 wrap", 0, '0, 0, '0, 3, 2'b01, 0);
        for (int i = 0; i < 3; i++) cyc("R7 sticky", 0, '0, 0, '0, 0, 2'b01, 0);
        wctl("R7 clear flag", 64'h0800_0000 | 64'h3_1000);
        wcnt("R11 load near wrap", 40'hFF_FFFF_FFFE);
        for (int i = 0; i < 3; i++) cyc("R8 irq line 1", 0, '0, 0, '0, 1, 2'b11, 0);

        // R12: clearing write in the cycle of an overflow keeps the flag
        wctl("R12 clear", 64'h0400_0000 | 64'h3_1000);
        wcnt("R11 load all ones", 40'hFF_FFFF_FFFF);
        cyc("R12 write during overflow", 1, 64'h0400_0000 | 64'h3_1000, 0, '0, 2, 2'b01, 0);
        cyc("R12 after", 0, '0, 0, '0, 0, 2'b01, 0);
        cyc("R12 new word active", 1, 64'h0, 0, '0, 4, 2'b01, 0);
        cyc("R12 disabled now", 0, '0, 0, '0, 4, 2'b01, 0);

        // R11: load wins over increment, load of all-ones raises nothing
        wctl("R11 enable", 64'h0400_0000 | 64'h3_1000);
        cyc("R11 load with event", 0, '0, 1, 40'hFF_FFFF_FFFF, 9, 2'b01, 0);
        cyc("R11 load over wrap", 0, '0, 1, 40'h12_3456_789A, 15, 2'b01, 0);
        cyc("R11 post load", 0, '0, 0, '0, 2, 2'b01, 0);

        // R9: forced overflow on every non-zero increment
        wctl("R9 force", 64'h0600_0000 | 64'h3_1000);
        for (int i = 0; i < 8; i++) cyc("R9 force seq", 0, '0, 0, '0, (i % 3 == 0) ? 0 : i, 2'b01, 0);
        wctl("R9 force cmp", 64'h0600_0000 | 64'h7_1000 | (64'd2 << 20));
        for (int i = 0; i < 8; i++) cyc("R9 force cmp seq", 0, '0, 0, '0, i, 2'b01, 0);

        // R10: cascade waits for the alternate pulse; rewrite disarms
        wctl("R10 cascade", 64'h4000_0000 | 64'h3_1000);
        for (int i = 0; i < 3; i++) cyc("R10 held", 0, '0, 0, '0, 2, 2'b01, 0);
        cyc("R10 alt pulse", 0, '0, 0, '0, 2, 2'b01, 1);
        for (int i = 0; i < 3; i++) cyc("R10 counting", 0, '0, 0, '0, 3, 2'b01, 0);
        wctl("R10 rewrite", 64'h4000_0000 | 64'h3_1000);
        for (int i = 0; i < 3; i++) cyc("R10 disarmed", 0, '0, 0, '0, 3, 2'b01, 0);
        wctl("R10 no cascade", 64'h3_1000);
        cyc("R10 alt ignored", 0, '0, 0, '0, 1, 2'b01, 1);
        wctl("R10 cascade again", 64'h4000_0000 | 64'h3_1000);
        cyc("R10 still disarmed", 0, '0, 0, '0, 1, 2'b01, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule